// File: doc/BRIEF.md
# Parallel/Serial Word Buffer

A first-in first-out buffer of 9-bit words where each side is chosen on its own to be a 9-bit parallel port or a one-bit serial port. The writer and the reader can therefore mix freely: serial in with parallel out, parallel in with serial out, serial on both sides, or parallel on both sides. The serial word length can be set anywhere from 4 to 9 bits. A serial word fills the low bits of a stored word, and the bits above it are zero.

The whole block runs on one clock, with enables for each kind of transfer. Six status outputs report how full the buffer is: empty, one word stored, above half, near either end, one slot left, and full. A replay input moves the read position back to the first location, so that a message already read can be sent again. A word written in one cycle can be read from the next cycle on.

Top module: `par_ser_fifo`

## Requirements
- R1: In parallel mode (`in_par_sel`=1, `out_par_sel`=1), a `wr_en` cycle stores `wr_data`, and `rd_data` always shows the oldest stored word. A word written into an empty buffer appears on `rd_data` one cycle after the write. Words leave in the order they were written.
- R2: With `in_par_sel`=0, each `ser_in_en` cycle takes one bit from `ser_in`, least significant bit first. After the programmed number of bits, the word is stored with its upper bits zero. Serial input is ignored in parallel mode, and any partial word is dropped.
- R3: With `out_par_sel`=0, `ser_out` shows bit k of the oldest word, starting at k=0. Each `ser_out_en` cycle moves to the next bit. After the last bit the word is removed, and `ser_word_done` is high for exactly the following cycle. When the buffer is empty, `ser_out` is 0 and nothing moves.
- R4: The effective serial width is `ser_width` clamped to the range 4..9.
- R5: `empty` is high at 0 words and `full` is high at DEPTH words. A write while full and a read while empty are ignored, and neither changes the stored contents.
- R6: `empty_p1` is high when exactly 1 word is stored. `full_m1` is high when exactly DEPTH-1 words are stored.
- R7: `half_full` is high when more than DEPTH/2 words are stored.
- R8: `almost` is high when DEPTH/8 words or fewer are stored, or when DEPTH-DEPTH/8 words or more are stored.
- R9: `retransmit` sets the read position to location 0 and the occupancy to the number of words written since reset, counting a write in the same cycle. It also restarts the serial output bit position. It is defined only while fewer than DEPTH words have been written since reset.
- R10: While `rst_n` is low, the buffer holds 0 words, so `empty` and `almost` are high and `full`, `full_m1` and `half_full` are low.
- R11: `rd_oe` is low whenever serial output mode is selected, and high in parallel output mode.
- R12: A read and a write in the same cycle leave the occupancy unchanged, except when the buffer is full (only the read takes effect) or empty (only the write takes effect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_par_sel | input | 1 | 1 = parallel write side, 0 = serial write side |
| out_par_sel | input | 1 | 1 = parallel read side, 0 = serial read side |
| ser_width | input | 4 | Serial word length, clamped to 4..9 |
| wr_en | input | 1 | Parallel write strobe |
| wr_data | input | 9 | Parallel write word |
| ser_in_en | input | 1 | Serial input bit strobe |
| ser_in | input | 1 | Serial input bit |
| rd_en | input | 1 | Parallel read strobe |
| rd_data | output | 9 | Oldest stored word |
| rd_oe | output | 1 | Parallel output enable |
| ser_out_en | input | 1 | Serial output bit strobe |
| ser_out | output | 1 | Current serial output bit |
| ser_word_done | output | 1 | One-cycle pulse after a serial word has been sent |
| retransmit | input | 1 | Rewind the read position to location 0 |
| full | output | 1 | DEPTH words stored |
| full_m1 | output | 1 | DEPTH-1 words stored |
| empty | output | 1 | No word stored |
| empty_p1 | output | 1 | One word stored |
| half_full | output | 1 | More than DEPTH/2 words stored |
| almost | output | 1 | Within DEPTH/8 of either end |

## Verification
The hardest case to reach is a serial word that is still being built or sent while its surroundings change. The width may change in the middle of a word, the side may switch to parallel mode, or a replay may land in the middle of a word while the buffer sits at a flag threshold. A directed pass walks the buffer from empty to full and back, one word at a time, so that every flag edge is seen. A long random pass then redraws the modes and the raw width (including values outside 4..9) every few hundred cycles, toggles the enables at random, and issues replays only while they are defined. The bench compares everything against its own model of the buffer.

// File: rtl/psf_pkg.sv
package psf_pkg;
   localparam int MIN_SER_W = 4;

   typedef struct packed {
      logic full;
      logic full_m1;
      logic empty;
      logic empty_p1;
      logic half;
      logic almost;
   } psf_flags_t;
endpackage

// File: rtl/psf_ram.sv
module psf_ram #(
   parameter int WORD_W = 9,
   parameter int DEPTH  = 2048,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   // unregistered read: head word is visible the cycle after it is written
   assign rdata = mem_q[raddr];
endmodule

// File: rtl/psf_ser_in.sv
module psf_ser_in #(
   parameter int WORD_W = 9,
   parameter int CW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift,
   input  logic              din,
   input  logic [CW-1:0]     width,
   output logic              word_vld,
   output logic [WORD_W-1:0] word
);
   logic [WORD_W-1:0] sh_q;
   logic [CW-1:0]     pos_q;
   logic              last;

   assign last = (pos_q >= width - CW'(1));

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      assign word[i] = (CW'(i) < width) &&
                       ((CW'(i) == pos_q) ? din : sh_q[i]);
   end

   assign word_vld = shift && !clear && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         pos_q <= '0;
      end else if (clear) begin
         sh_q  <= '0;
         pos_q <= '0;
      end else if (shift) begin
         if (last) begin
            sh_q  <= '0;
            pos_q <= '0;
         end else begin
            sh_q  <= word;
            pos_q <= pos_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/psf_ser_out.sv
module psf_ser_out #(
   parameter int WORD_W = 9,
   parameter int CW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift,
   input  logic              avail,
   input  logic [CW-1:0]     width,
   input  logic [WORD_W-1:0] head,
   output logic              dout,
   output logic              pop,
   output logic              done
);
   logic [CW-1:0] pos_q;
   logic          last;
   logic          sel_bit;

   assign last = (pos_q >= width - CW'(1));

   always_comb begin
      sel_bit = 1'b0;
      for (int i = 0; i < WORD_W; i++) begin
         if (CW'(i) == pos_q) sel_bit = head[i];
      end
   end

   assign dout = avail && sel_bit;
   assign pop  = shift && avail && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= pop;
         if (clear)                pos_q <= '0;
         else if (shift && avail)  pos_q <= last ? '0 : pos_q + CW'(1);
      end
   end
endmodule

// File: rtl/psf_ctrl.sv
module psf_ctrl
   import psf_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          retx,
   output logic          push_ok,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output psf_flags_t    flags
);
   localparam logic [AW:0] C_FULL   = (AW+1)'(DEPTH);
   localparam logic [AW:0] C_FULLM1 = (AW+1)'(DEPTH - 1);
   localparam logic [AW:0] C_HALF   = (AW+1)'(DEPTH / 2);
   localparam logic [AW:0] C_LOW    = (AW+1)'(DEPTH / 8);
   localparam logic [AW:0] C_HIGH   = (AW+1)'(DEPTH - DEPTH / 8);

   logic [AW:0] cnt_q;
   logic        pop_ok;

   assign push_ok = push && (cnt_q != C_FULL);
   assign pop_ok  = pop && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waddr <= '0;
         raddr <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) waddr <= waddr + AW'(1);
         if (retx) begin
            raddr <= '0;
            cnt_q <= {1'b0, waddr} + (AW+1)'(push_ok);
         end else begin
            if (pop_ok) raddr <= raddr + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
         end
      end
   end

   always_comb begin
      flags.full     = (cnt_q == C_FULL);
      flags.full_m1  = (cnt_q == C_FULLM1);
      flags.empty    = (cnt_q == '0);
      flags.empty_p1 = (cnt_q == (AW+1)'(1));
      flags.half     = (cnt_q > C_HALF);
      flags.almost   = (cnt_q <= C_LOW) || (cnt_q >= C_HIGH);
   end
endmodule

// File: rtl/par_ser_fifo.sv
module par_ser_fifo
   import psf_pkg::*;
#(
   parameter int  WORD_W = 9,
   parameter int  DEPTH  = 2048,
   localparam int AW     = $clog2(DEPTH),
   localparam int CW     = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_par_sel,
   input  logic              out_par_sel,
   input  logic [CW-1:0]     ser_width,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              ser_in_en,
   input  logic              ser_in,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_oe,
   input  logic              ser_out_en,
   output logic              ser_out,
   output logic              ser_word_done,
   input  logic              retransmit,
   output logic              full,
   output logic              full_m1,
   output logic              empty,
   output logic              empty_p1,
   output logic              half_full,
   output logic              almost
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 16) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 16");
   end
   if (WORD_W < MIN_SER_W) begin : g_bad_width
      $error("WORD_W must be at least MIN_SER_W");
   end

   localparam logic [CW-1:0] W_MIN = CW'(MIN_SER_W);
   localparam logic [CW-1:0] W_MAX = CW'(WORD_W);

   logic [CW-1:0]     eff_w;
   logic              si_vld, so_pop, push, pop, push_ok;
   logic [WORD_W-1:0] si_word, wdata;
   logic [AW-1:0]     waddr, raddr;
   psf_flags_t        flg;

   assign eff_w = (ser_width < W_MIN) ? W_MIN :
                  (ser_width > W_MAX) ? W_MAX : ser_width;

   psf_ser_in #(.WORD_W(WORD_W), .CW(CW)) u_sin (
      .clk(clk), .rst_n(rst_n), .clear(in_par_sel), .shift(ser_in_en),
      .din(ser_in), .width(eff_w), .word_vld(si_vld), .word(si_word));

   assign push  = in_par_sel ? wr_en : si_vld;
   assign wdata = in_par_sel ? wr_data : si_word;

   psf_ser_out #(.WORD_W(WORD_W), .CW(CW)) u_sout (
      .clk(clk), .rst_n(rst_n), .clear(out_par_sel || retransmit),
      .shift(ser_out_en && !out_par_sel), .avail(!flg.empty),
      .width(eff_w), .head(rd_data), .dout(ser_out), .pop(so_pop),
      .done(ser_word_done));

   assign pop = out_par_sel ? rd_en : so_pop;

   psf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .retx(retransmit),
      .push_ok(push_ok), .waddr(waddr), .raddr(raddr), .flags(flg));

   psf_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
      .clk(clk), .we(push_ok), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rd_data));

   assign rd_oe     = out_par_sel;
   assign full      = flg.full;
   assign full_m1   = flg.full_m1;
   assign empty     = flg.empty;
   assign empty_p1  = flg.empty_p1;
   assign half_full = flg.half;
   assign almost    = flg.almost;
endmodule

// File: rtl/psf_checker.sv
module psf_checker (
   input logic clk,
   input logic rst_n,
   input logic in_par_sel,
   input logic out_par_sel,
   input logic wr_en,
   input logic rd_en,
   input logic ser_in_en,
   input logic ser_out_en,
   input logic retransmit,
   input logic ser_word_done,
   input logic full,
   input logic full_m1,
   input logic empty,
   input logic half_full,
   input logic almost
);
   assert_reset_state_R10: assert property (@(posedge clk)
      !rst_n |=> (empty && almost && !full) || !rst_n);

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      full && in_par_sel && wr_en && !(out_par_sel && rd_en) &&
      !(!out_par_sel && ser_out_en) && !retransmit |=> full);

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      empty && out_par_sel && !(in_par_sel && wr_en) &&
      !(!in_par_sel && ser_in_en) && !retransmit |=> empty);

   assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   assert_full_via_m1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) && !$past(retransmit) |-> $past(full_m1));

   assert_half_not_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      half_full |-> !empty);

   assert_full_is_almost_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> almost && half_full);

   assert_done_serial_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ser_word_done |-> $past(ser_out_en) && !$past(out_par_sel) && !$past(empty));

   assert_full_rw_R12: assert property (@(posedge clk) disable iff (!rst_n)
      full && in_par_sel && wr_en && out_par_sel && rd_en && !retransmit
      |=> full_m1);
endmodule

bind par_ser_fifo psf_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_par_sel(in_par_sel), .out_par_sel(out_par_sel),
   .wr_en(wr_en), .rd_en(rd_en), .ser_in_en(ser_in_en), .ser_out_en(ser_out_en),
   .retransmit(retransmit), .ser_word_done(ser_word_done), .full(full),
   .full_m1(full_m1), .empty(empty), .half_full(half_full), .almost(almost));

// File: tb/par_ser_fifo_test.sv
`timescale 1ns/1ps
module par_ser_fifo_test;
   localparam int D = 64;
   localparam int CLK_NS = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_par_sel = 1'b1, out_par_sel = 1'b1;
   logic [3:0] ser_width = 4'd9;
   logic       wr_en = 0, ser_in_en = 0, ser_in = 0, rd_en = 0;
   logic       ser_out_en = 0, retransmit = 0;
   logic [8:0] wr_data = '0;
   logic [8:0] rd_data;
   logic       rd_oe, ser_out, ser_word_done;
   logic       full, full_m1, empty, empty_p1, half_full, almost;

   par_ser_fifo #(.WORD_W(9), .DEPTH(D)) uut (.*);

   always #(CLK_NS/2) clk = ~clk;

   int n_run = 0, n_fail = 0;
   logic [8:0] mem_m [D];
   int wp, rp, cnt, icnt, ocnt, wtot;
   logic [8:0] sh;
   bit done_m;

   task automatic chk(input string req, input string nm, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, nm, act, exp, $time);
      end
   endtask

   function automatic int clampw(input int w);
      return (w < 4) ? 4 : ((w > 9) ? 9 : w);
   endfunction

   task automatic model_reset();
      wp = 0; rp = 0; cnt = 0; icnt = 0; ocnt = 0; wtot = 0; sh = '0; done_m = 0;
   endtask

   task automatic model_step();
      int w; bit push, pop, pok, wok, spop; logic [8:0] wd;
      w = clampw(int'(ser_width));
      push = 0; wd = '0;
      if (in_par_sel) begin
         push = wr_en; wd = wr_data; sh = '0; icnt = 0;
      end else if (ser_in_en) begin
         for (int i = 0; i < 9; i++)
            wd[i] = (i < w) && ((i == icnt) ? ser_in : sh[i]);
         if (icnt >= w - 1) begin push = 1; sh = '0; icnt = 0; end
         else begin sh = wd; icnt++; end
      end
      spop = !out_par_sel && ser_out_en && cnt > 0 && ocnt >= w - 1;
      pop = out_par_sel ? rd_en : spop;
      done_m = spop;
      if (out_par_sel || retransmit) ocnt = 0;
      else if (ser_out_en && cnt > 0) ocnt = (ocnt >= w - 1) ? 0 : ocnt + 1;
      wok = push && cnt != D;
      pok = pop && cnt != 0;
      if (retransmit) begin
         rp = 0; cnt = wp + int'(wok);
      end else begin
         rp = (rp + int'(pok)) % D; cnt = cnt + int'(wok) - int'(pok);
      end
      if (wok) begin mem_m[wp] = wd; wp = (wp + 1) % D; wtot++; end
   endtask

   task automatic check_all(input string tag);
      chk("R5", {tag, " empty"}, int'(empty), int'(cnt == 0));
      chk("R5", {tag, " full"}, int'(full), int'(cnt == D));
      chk("R6", {tag, " empty_p1"}, int'(empty_p1), int'(cnt == 1));
      chk("R6", {tag, " full_m1"}, int'(full_m1), int'(cnt == D - 1));
      chk("R7", {tag, " half_full"}, int'(half_full), int'(cnt > D / 2));
      chk("R8", {tag, " almost"}, int'(almost), int'(cnt <= D / 8 || cnt >= D - D / 8));
      chk("R11", {tag, " rd_oe"}, int'(rd_oe), int'(out_par_sel));
      chk("R3", {tag, " word_done"}, int'(ser_word_done), int'(done_m));
      if (cnt > 0) begin
         chk("R1", {tag, " rd_data"}, int'(rd_data), int'(mem_m[rp]));
         if (!out_par_sel)
            chk("R3", {tag, " ser_out"}, int'(ser_out), int'(mem_m[rp][ocnt]));
      end else if (!out_par_sel) begin
         chk("R3", {tag, " ser_out empty"}, int'(ser_out), 0);
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all(tag);
      wr_en = 0; rd_en = 0; ser_in_en = 0; ser_out_en = 0; retransmit = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      @(negedge clk); @(negedge clk);
      model_reset();
      chk("R10", "reset empty", int'(empty), 1);
      chk("R10", "reset almost", int'(almost), 1);
      chk("R10", "reset full", int'(full), 0);
      chk("R10", "reset half", int'(half_full), 0);
      rst_n = 1;
   endtask

   task automatic ser_send(input int val, input int nbits);
      for (int b = 0; b < nbits; b++) begin
         ser_in_en = 1; ser_in = val[b];
         tick("R2 serial in");
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();

      // R1/R5..R8: parallel fill to full, one word per cycle
      for (int i = 0; i < D; i++) begin
         wr_en = 1; wr_data = 9'((i * 37 + 5) & 9'h1FF);
         tick("R1 fill");
      end
      wr_en = 1; wr_data = 9'h1AA;
      tick("R5 write while full");
      chk("R5", "head unchanged after overflow", int'(rd_data), 5);
      // R12: read and write while full
      wr_en = 1; wr_data = 9'h0F0; rd_en = 1;
      tick("R12 full rw");
      chk("R12", "full_m1 after full rw", int'(full_m1), 1);
      for (int i = 0; i < D; i++) begin
         rd_en = 1; tick("R1 drain");
      end
      rd_en = 1; tick("R5 read while empty");
      chk("R5", "empty after underflow", int'(empty), 1);
      // R12: read and write while empty; zero fall-through
      wr_en = 1; wr_data = 9'h123; rd_en = 1;
      tick("R12 empty rw");
      chk("R1", "fall-through data", int'(rd_data), 9'h123);
      wr_en = 1; wr_data = 9'h045; rd_en = 1;
      tick("R12 steady rw");
      chk("R12", "one word remains", int'(empty_p1), 1);
      rd_en = 1; tick("drain");

      // R2: serial in width 5, parallel out
      in_par_sel = 0; ser_width = 4'd5;
      ser_send(5'b10110, 5);
      ser_send(5'b00011, 5);
      chk("R2", "serial word 1", int'(rd_data), 9'h016);
      rd_en = 1; tick("R2 read");
      chk("R2", "serial word 2", int'(rd_data), 9'h003);
      rd_en = 1; tick("R2 read");
      // R4: width 2 clamps to 4, width 13 clamps to 9
      ser_width = 4'd2;
      ser_send(4'b1101, 4);
      chk("R4", "clamped low width", int'(rd_data), 9'h00D);
      rd_en = 1; tick("R4 read");
      ser_width = 4'd13;
      ser_send(9'h1A5, 9);
      chk("R4", "clamped high width", int'(rd_data), 9'h1A5);
      rd_en = 1; tick("R4 read");

      // R3: parallel in, serial out width 9
      in_par_sel = 1; out_par_sel = 0; ser_width = 4'd9;
      wr_en = 1; wr_data = 9'h15B; tick("R3 load");
      wr_en = 1; wr_data = 9'h0C4; tick("R3 load");
      for (int b = 0; b < 18; b++) begin
         ser_out_en = 1; tick("R3 serial out");
      end
      ser_out_en = 1; tick("R3 serial out empty");

      // R9: replay
      out_par_sel = 1;
      do_reset();
      for (int i = 0; i < 5; i++) begin
         wr_en = 1; wr_data = 9'(i + 40); tick("R9 load");
      end
      for (int i = 0; i < 3; i++) begin
         rd_en = 1; tick("R9 read");
      end
      retransmit = 1; tick("R9 rewind");
      chk("R9", "replayed head", int'(rd_data), 40);
      chk("R9", "not half", int'(half_full), 0);

      // random phase
      do_reset();
      for (int ph = 0; ph < 20; ph++) begin
         in_par_sel = 1'($urandom_range(0, 1));
         out_par_sel = 1'($urandom_range(0, 1));
         ser_width = 4'($urandom_range(0, 15));
         for (int c = 0; c < 200; c++) begin
            wr_en = 1'($urandom_range(0, 1));
            wr_data = 9'($urandom_range(0, 511));
            ser_in_en = 1'($urandom_range(0, 3) != 0);
            ser_in = 1'($urandom_range(0, 1));
            rd_en = 1'($urandom_range(0, 2) == 0);
            ser_out_en = 1'($urandom_range(0, 2) != 0);
            retransmit = 1'(wtot < D - 2 && $urandom_range(0, 63) == 0);
            if (c % 50 == 49) ser_width = 4'($urandom_range(0, 15));
            tick("random");
         end
         if (ph % 5 == 4) do_reset();
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
   end
endmodule